// File: doc/BRIEF.md
# Dual-Clock Bidirectional Buffer Port Controller

This block joins two independent synchronous ports, A and B, through a pair of opposite-direction first-in first-out stores. Each port runs on its own clock. Each port presents a chip select, a read/write select, an enable, an output enable and a 3-bit address. A port command is taken on a rising edge of the port's clock only when both chip select and enable are high. The read/write select then gives the direction for that edge: 1 reads, 0 writes. The address picks what the command works on. It can be the buffered word stream, a direct path to the opposite port's input register, or one of the port's two threshold offset registers.

Every read result lands in the port's output register. Each port also reports four flags. Empty and almost-empty describe the store it reads. Full and almost-full describe the store it writes. A port opens the direct path by issuing write commands with the direct-path address. The opposite port sees a bypass flag while that path may be read, and one clock of grace remains after the sender stops. A direct-path read issued outside that window is treated as an ordinary stream read. The data output is driven only while output enable is high. Otherwise it reads as zero, which stands in for a released bus.

Top module: `bififo_ctrl`

## Requirements
- R1: After reset both output registers hold zero, both ports report empty and almost-empty high, full and almost-full low, and the bypass flag low.
- R2: A write with address 000 on one port, when that port's full flag is low, appends the data word to the store read by the opposite port. A read with address 000 there, when empty is low, loads the oldest word into the output register and retires it, so words come out in the order they were written.
- R3: A stream read issued while empty is high leaves the output register unchanged. A stream write issued while full is high is discarded. Full is high when the writer's view of the word count equals DEPTH.
- R4: Each side sees the other side's pointer two of its own clocks late. A word written at edge n becomes readable at edge n+3 of an equal, in-phase clock. In the same way, a slot freed by a read shows on the writer's full flag two clocks later.
- R5: A command is taken only when chip select and enable are both high at the port's rising edge. Otherwise the output register, pointers and offsets keep their values.
- R6: A write with address 010 loads the low log2(DEPTH)+1 data bits into the port's almost-empty offset. Address 011 loads the almost-full offset in the same way. A read with address 010 or 011 returns that offset, zero-extended, through the output register.
- R7: Almost-empty is high when the reader's word count is at most the almost-empty offset. Almost-full is high when the writer's word count plus the almost-full offset is at least DEPTH.
- R8: Any write command loads the port's input register. A read with address 001 inside the bypass window copies the opposite port's input register into the output register and moves no pointer of either store.
- R9: The bypass flag goes high two clocks after the opposite port's first write with address 001. It stays high for one clock after the last such write has been seen, so the window is the offer delay plus one cycle. A read with address 001 while the flag is low acts as a read with address 000.
- R10: Addresses 100 to 111 are no-operations. A read leaves the output register unchanged. A write changes only the input register.
- R11: While output enable is low the port's data output is zero, and the output register is kept for when it rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Synchronous active-low reset, seen by both clock domains |
| a_clk | input | 1 | Port A clock |
| a_cs | input | 1 | Port A chip select |
| a_rw | input | 1 | Port A direction, 1 read, 0 write |
| a_en | input | 1 | Port A command enable |
| a_oe | input | 1 | Port A output drive enable |
| a_addr | input | 3 | Port A target select |
| a_din | input | W | Port A write data |
| a_dout | output | W | Port A output register, zero while a_oe is low |
| a_empty | output | 1 | Store read by A holds no word |
| a_aempty | output | 1 | Store read by A at or below its almost-empty offset |
| a_full | output | 1 | Store written by A holds DEPTH words |
| a_afull | output | 1 | Store written by A within its almost-full offset of DEPTH |
| a_byp | output | 1 | Port B's input register may be read by A |
| b_clk | input | 1 | Port B clock |
| b_cs | input | 1 | Port B chip select |
| b_rw | input | 1 | Port B direction, 1 read, 0 write |
| b_en | input | 1 | Port B command enable |
| b_oe | input | 1 | Port B output drive enable |
| b_addr | input | 3 | Port B target select |
| b_din | input | W | Port B write data |
| b_dout | output | W | Port B output register, zero while b_oe is low |
| b_empty | output | 1 | Store read by B holds no word |
| b_aempty | output | 1 | Store read by B at or below its almost-empty offset |
| b_full | output | 1 | Store written by B holds DEPTH words |
| b_afull | output | 1 | Store written by B within its almost-full offset of DEPTH |
| b_byp | output | 1 | Port A's input register may be read by B |

## Verification
Each property is clocked by the port whose signals it names, so the assertions assume nothing about the ratio of the two clocks. They do assume that rst_n is held low for at least two edges of each clock, and that the input register being offered does not change while the bypass window is open. The reason is that this register crosses the clock boundary without resynchronisation. The stimulus drives both clocks from one 50 MHz source in phase. That makes the two-clock pointer delay exact, so the per-edge model can predict every flag. Data written with address 001 is held constant for the whole offer.

// File: rtl/bififo_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the bidirectional buffer controller.
// Assumes: the 3-bit port address is decoded through sel_e; codes not listed are no-operations.
package bififo_pkg;
    typedef enum logic [2:0] {
        SEL_FIFO  = 3'b000,
        SEL_BYP   = 3'b001,
        SEL_AEOFS = 3'b010,
        SEL_AFOFS = 3'b011
    } sel_e;
endpackage

// File: rtl/bififo_sync.sv
`timescale 1ns/1ps
// Two-stage synchronizer for signals crossing into clk.
// Assumes: multi-bit inputs change at most one bit per source clock (Gray coded) or are quasi-static.
module bififo_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Shift the asynchronous input through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/bififo_store.sv
`timescale 1ns/1ps
// Dual-clock word store: write side on wclk, read side on rclk.
// Each side sees the other's Gray pointer after two of its own clocks.
// Assumes: DEPTH is a power of two; push is never raised when the writer's count equals DEPTH,
// pop never when the reader's count is zero.
module bififo_store #(
    parameter int W     = 18,
    parameter int DEPTH = 64
) (
    input  logic                       wclk,
    input  logic                       rclk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    output logic [$clog2(DEPTH):0]     wr_count,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH):0]     rd_count
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] wbin_nx, rbin_nx;
    logic [PW-1:0] rgray_w, wgray_r;

    function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    assign wbin_nx = wbin + PW'(push);
    assign rbin_nx = rbin + PW'(pop);

    // Advance the write pointer and its Gray copy together.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    // Store the incoming word at the write address.
    always_ff @(posedge wclk) begin
        if (push) begin
            mem[wbin[AW-1:0]] <= wdata;
        end
    end

    // Advance the read pointer and its Gray copy together.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    bififo_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_w));
    bififo_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_r));

    assign wr_count = wbin - gray2bin(rgray_w);
    assign rd_count = gray2bin(wgray_r) - rbin;
    assign rdata    = mem[rbin[AW-1:0]];
endmodule

// File: rtl/bififo_port.sv
`timescale 1ns/1ps
// One port of the controller: decodes commands, owns the input, output and offset registers,
// computes its four flags and manages the incoming bypass window.
// Assumes: peer_din_q is stable while peer_offer is high (it crosses unsynchronised).
module bififo_port
    import bififo_pkg::*;
#(
    parameter int W     = 18,
    parameter int DEPTH = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs,
    input  logic                   rw,
    input  logic                   en,
    input  logic                   oe,
    input  logic [2:0]             addr,
    input  logic [W-1:0]           din,
    output logic [W-1:0]           dout,
    output logic                   empty,
    output logic                   aempty,
    output logic                   full,
    output logic                   afull,
    output logic                   byp_ok,
    output logic                   offer,
    output logic [W-1:0]           din_q,
    input  logic                   peer_offer,
    input  logic [W-1:0]           peer_din_q,
    input  logic [$clog2(DEPTH):0] wr_count,
    output logic                   push,
    output logic [W-1:0]           wdata,
    input  logic [$clog2(DEPTH):0] rd_count,
    input  logic [W-1:0]           rdata,
    output logic                   pop
);
    localparam int PW = $clog2(DEPTH) + 1;

    logic          cmd, wr_cmd, rd_cmd;
    sel_e          sel, eff_sel;
    logic [PW-1:0] ae_q, af_q;
    logic [W-1:0]  out_q;
    logic          seen, seen_d;

    assign cmd    = cs && en;
    assign wr_cmd = cmd && !rw;
    assign rd_cmd = cmd && rw;
    assign sel    = sel_e'(addr);

    assign empty  = (rd_count == '0);
    assign aempty = (rd_count <= ae_q);
    assign full   = (wr_count == PW'(DEPTH));
    assign afull  = (({1'b0, wr_count} + {1'b0, af_q}) >= (PW+1)'(DEPTH));

    bififo_sync #(.W(1)) u_offer_sync (.clk(clk), .rst_n(rst_n), .d(peer_offer), .q(seen));

    // Stretch the synchronized offer by one cycle of grace.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_d <= 1'b0;
        else        seen_d <= seen;
    end

    assign byp_ok  = seen || seen_d;
    assign eff_sel = (sel == SEL_BYP && !byp_ok) ? SEL_FIFO : sel;

    assign push  = wr_cmd && (sel == SEL_FIFO) && !full;
    assign wdata = din;
    assign pop   = rd_cmd && (eff_sel == SEL_FIFO) && !empty;

    // Capture write data, program offsets and mark bypass offers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_q <= '0;
            ae_q  <= '0;
            af_q  <= '0;
            offer <= 1'b0;
        end else begin
            offer <= wr_cmd && (sel == SEL_BYP);
            if (wr_cmd) begin
                din_q <= din;
                if (sel == SEL_AEOFS) ae_q <= din[PW-1:0];
                if (sel == SEL_AFOFS) af_q <= din[PW-1:0];
            end
        end
    end

    // Steer the selected source into the output register on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (rd_cmd) begin
            case (eff_sel)
                SEL_FIFO:  if (!empty) out_q <= rdata;
                SEL_BYP:   out_q <= peer_din_q;
                SEL_AEOFS: out_q <= W'(ae_q);
                SEL_AFOFS: out_q <= W'(af_q);
                default:   ;
            endcase
        end
    end

    assign dout = oe ? out_q : '0;
endmodule

// File: rtl/bififo_ctrl.sv
`timescale 1ns/1ps
// Top of the bidirectional buffer controller: two ports and two opposite-direction stores.
// Index 0 is port A, index 1 is port B; store g is written by port g and read by the other.
// Assumes: DEPTH is a power of two and W >= log2(DEPTH)+1.
module bififo_ctrl #(
    parameter int W     = 18,
    parameter int DEPTH = 64
) (
    input  logic         rst_n,
    input  logic         a_clk,
    input  logic         a_cs,
    input  logic         a_rw,
    input  logic         a_en,
    input  logic         a_oe,
    input  logic [2:0]   a_addr,
    input  logic [W-1:0] a_din,
    output logic [W-1:0] a_dout,
    output logic         a_empty,
    output logic         a_aempty,
    output logic         a_full,
    output logic         a_afull,
    output logic         a_byp,
    input  logic         b_clk,
    input  logic         b_cs,
    input  logic         b_rw,
    input  logic         b_en,
    input  logic         b_oe,
    input  logic [2:0]   b_addr,
    input  logic [W-1:0] b_din,
    output logic [W-1:0] b_dout,
    output logic         b_empty,
    output logic         b_aempty,
    output logic         b_full,
    output logic         b_afull,
    output logic         b_byp
);
    localparam int PW = $clog2(DEPTH) + 1;

    logic          clk_v [2];
    logic          cs_v [2], rw_v [2], en_v [2], oe_v [2];
    logic [2:0]    addr_v [2];
    logic [W-1:0]  din_v [2], dout_v [2], din_q_v [2];
    logic          empty_v [2], aempty_v [2], full_v [2], afull_v [2], byp_v [2], offer_v [2];
    logic          st_push [2], st_pop [2];
    logic [W-1:0]  st_wdata [2], st_rdata [2];
    logic [PW-1:0] st_wr_cnt [2], st_rd_cnt [2];

    assign clk_v[0] = a_clk;   assign clk_v[1] = b_clk;
    assign cs_v[0]  = a_cs;    assign cs_v[1]  = b_cs;
    assign rw_v[0]  = a_rw;    assign rw_v[1]  = b_rw;
    assign en_v[0]  = a_en;    assign en_v[1]  = b_en;
    assign oe_v[0]  = a_oe;    assign oe_v[1]  = b_oe;
    assign addr_v[0] = a_addr; assign addr_v[1] = b_addr;
    assign din_v[0]  = a_din;  assign din_v[1]  = b_din;

    assign a_dout = dout_v[0];   assign b_dout = dout_v[1];
    assign a_empty = empty_v[0]; assign b_empty = empty_v[1];
    assign a_aempty = aempty_v[0]; assign b_aempty = aempty_v[1];
    assign a_full = full_v[0];   assign b_full = full_v[1];
    assign a_afull = afull_v[0]; assign b_afull = afull_v[1];
    assign a_byp = byp_v[0];     assign b_byp = byp_v[1];

    for (genvar g = 0; g < 2; g++) begin : g_side
        bififo_port #(.W(W), .DEPTH(DEPTH)) u_port (
            .clk(clk_v[g]), .rst_n(rst_n),
            .cs(cs_v[g]), .rw(rw_v[g]), .en(en_v[g]), .oe(oe_v[g]),
            .addr(addr_v[g]), .din(din_v[g]), .dout(dout_v[g]),
            .empty(empty_v[g]), .aempty(aempty_v[g]), .full(full_v[g]), .afull(afull_v[g]),
            .byp_ok(byp_v[g]), .offer(offer_v[g]), .din_q(din_q_v[g]),
            .peer_offer(offer_v[1-g]), .peer_din_q(din_q_v[1-g]),
            .wr_count(st_wr_cnt[g]), .push(st_push[g]), .wdata(st_wdata[g]),
            .rd_count(st_rd_cnt[1-g]), .rdata(st_rdata[1-g]), .pop(st_pop[1-g])
        );

        bififo_store #(.W(W), .DEPTH(DEPTH)) u_store (
            .wclk(clk_v[g]), .rclk(clk_v[1-g]), .rst_n(rst_n),
            .push(st_push[g]), .wdata(st_wdata[g]), .wr_count(st_wr_cnt[g]),
            .pop(st_pop[g]), .rdata(st_rdata[g]), .rd_count(st_rd_cnt[g])
        );
    end
endmodule

// File: rtl/bififo_ctrl_chk.sv
`timescale 1ns/1ps
// Port-level properties of bififo_ctrl; each one is clocked by the port it observes.
// Assumes: rst_n is low from time zero for at least two edges of each clock.
module bififo_ctrl_chk #(
    parameter int W = 18
) (
    input logic         rst_n,
    input logic         a_clk,
    input logic         a_cs,
    input logic         a_rw,
    input logic         a_en,
    input logic         a_oe,
    input logic [2:0]   a_addr,
    input logic [W-1:0] a_dout,
    input logic         a_empty,
    input logic         a_aempty,
    input logic         a_full,
    input logic         a_afull,
    input logic         a_byp,
    input logic         b_clk,
    input logic         b_cs,
    input logic         b_rw,
    input logic         b_en,
    input logic         b_oe,
    input logic [2:0]   b_addr,
    input logic [W-1:0] b_dout,
    input logic         b_empty,
    input logic         b_aempty,
    input logic         b_full,
    input logic         b_afull,
    input logic         b_byp
);
    assert_idle_hold_a_R5: assert property (@(posedge a_clk) disable iff (!rst_n)
        (!(a_cs && a_en && a_rw) && a_oe) |=> (!a_oe || $stable(a_dout)));

    assert_idle_hold_b_R5: assert property (@(posedge b_clk) disable iff (!rst_n)
        (!(b_cs && b_en && b_rw) && b_oe) |=> (!b_oe || $stable(b_dout)));

    assert_empty_read_hold_a_R3: assert property (@(posedge a_clk) disable iff (!rst_n)
        (a_cs && a_en && a_rw && a_addr == 3'b000 && a_empty && a_oe) |=> (!a_oe || $stable(a_dout)));

    assert_empty_read_hold_b_R3: assert property (@(posedge b_clk) disable iff (!rst_n)
        (b_cs && b_en && b_rw && b_addr == 3'b000 && b_empty && b_oe) |=> (!b_oe || $stable(b_dout)));

    assert_full_has_afull_a_R7: assert property (@(posedge a_clk) disable iff (!rst_n)
        a_full |-> a_afull);

    assert_empty_has_aempty_b_R7: assert property (@(posedge b_clk) disable iff (!rst_n)
        b_empty |-> b_aempty);

    assert_bypass_grace_a_R9: assert property (@(posedge a_clk) disable iff (!rst_n)
        $rose(a_byp) |=> a_byp);

    assert_bypass_grace_b_R9: assert property (@(posedge b_clk) disable iff (!rst_n)
        $rose(b_byp) |=> b_byp);
endmodule

bind bififo_ctrl bififo_ctrl_chk #(.W(W)) u_chk (
    .rst_n(rst_n),
    .a_clk(a_clk), .a_cs(a_cs), .a_rw(a_rw), .a_en(a_en), .a_oe(a_oe), .a_addr(a_addr),
    .a_dout(a_dout), .a_empty(a_empty), .a_aempty(a_aempty), .a_full(a_full),
    .a_afull(a_afull), .a_byp(a_byp),
    .b_clk(b_clk), .b_cs(b_cs), .b_rw(b_rw), .b_en(b_en), .b_oe(b_oe), .b_addr(b_addr),
    .b_dout(b_dout), .b_empty(b_empty), .b_aempty(b_aempty), .b_full(b_full),
    .b_afull(b_afull), .b_byp(b_byp)
);

// File: tb/sim_bififo_ctrl.sv
`timescale 1ns/1ps
// Bench for bififo_ctrl: both ports run from one 50 MHz clock.
// A behavioural per-edge model (queues and pointer histories) is compared on every clock.
module sim_bififo_ctrl;
    localparam int W = 18;
    localparam int DEPTH = 8;
    localparam int OMASK = 15;  // low log2(DEPTH)+1 bits
    localparam int HMAX = 2048;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic i_cs [2], i_rw [2], i_en [2], i_oe [2];
    logic [2:0] i_addr [2];
    logic [W-1:0] i_din [2];
    logic [W-1:0] a_dout, b_dout;
    logic a_empty, a_aempty, a_full, a_afull, a_byp;
    logic b_empty, b_aempty, b_full, b_afull, b_byp;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    bififo_ctrl #(.W(W), .DEPTH(DEPTH)) u0 (
        .rst_n(rst_n),
        .a_clk(clk), .a_cs(i_cs[0]), .a_rw(i_rw[0]), .a_en(i_en[0]), .a_oe(i_oe[0]),
        .a_addr(i_addr[0]), .a_din(i_din[0]), .a_dout(a_dout),
        .a_empty(a_empty), .a_aempty(a_aempty), .a_full(a_full), .a_afull(a_afull), .a_byp(a_byp),
        .b_clk(clk), .b_cs(i_cs[1]), .b_rw(i_rw[1]), .b_en(i_en[1]), .b_oe(i_oe[1]),
        .b_addr(i_addr[1]), .b_din(i_din[1]), .b_dout(b_dout),
        .b_empty(b_empty), .b_aempty(b_aempty), .b_full(b_full), .b_afull(b_afull), .b_byp(b_byp)
    );

    // Reference model state
    int e = 0;
    int wp [2][HMAX];
    int rp [2][HMAX];
    int off [2][HMAX];
    logic [W-1:0] q0 [$];
    logic [W-1:0] q1 [$];
    logic [W-1:0] inreg [2];
    logic [W-1:0] outr [2];
    int aeo [2];
    int afo [2];

    function automatic int gwp(int p, int i); return (i < 0) ? 0 : wp[p][i]; endfunction
    function automatic int grp(int p, int i); return (i < 0) ? 0 : rp[p][i]; endfunction
    function automatic int goff(int p, int i); return (i < 0) ? 0 : off[p][i]; endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (edge %0d)", req, what, act, exp, e);
        end
    endtask

    task automatic model_step();
        int rc_pre [2];
        int wc_pre [2];
        bit win [2], psh [2], pp [2], rd [2], wr [2];
        int eff [2];
        logic [W-1:0] in_pre [2];
        e++;
        for (int p = 0; p < 2; p++) begin
            rc_pre[p] = gwp(1-p, e-3) - grp(1-p, e-1);
            wc_pre[p] = gwp(p, e-1) - grp(p, e-3);
            win[p] = (goff(1-p, e-3) | goff(1-p, e-4)) != 0;
            in_pre[p] = inreg[p];
        end
        for (int p = 0; p < 2; p++) begin
            rd[p] = i_cs[p] && i_en[p] && i_rw[p];
            wr[p] = i_cs[p] && i_en[p] && !i_rw[p];
            psh[p] = wr[p] && i_addr[p] == 3'd0 && wc_pre[p] != DEPTH;
            eff[p] = (rd[p] && i_addr[p] == 3'd1 && !win[p]) ? 0 : int'(i_addr[p]);
            pp[p] = rd[p] && eff[p] == 0 && rc_pre[p] != 0;
            if (rd[p]) begin
                case (eff[p])
                    0: if (pp[p]) outr[p] = (p == 0) ? q1[0] : q0[0];
                    1: outr[p] = in_pre[1-p];
                    2: outr[p] = W'(aeo[p]);
                    3: outr[p] = W'(afo[p]);
                    default: ;
                endcase
            end
        end
        if (pp[0]) void'(q1.pop_front());
        if (pp[1]) void'(q0.pop_front());
        if (psh[0]) q0.push_back(i_din[0]);
        if (psh[1]) q1.push_back(i_din[1]);
        for (int p = 0; p < 2; p++) begin
            if (wr[p]) begin
                inreg[p] = i_din[p];
                if (i_addr[p] == 3'd2) aeo[p] = int'(i_din[p]) & OMASK;
                if (i_addr[p] == 3'd3) afo[p] = int'(i_din[p]) & OMASK;
            end
            wp[p][e] = gwp(p, e-1) + int'(psh[p]);
            rp[1-p][e] = grp(1-p, e-1) + int'(pp[p]);
            off[p][e] = int'(wr[p] && i_addr[p] == 3'd1);
        end
    endtask

    task automatic compare();
        for (int p = 0; p < 2; p++) begin
            int rc, wc, xd;
            rc = gwp(1-p, e-2) - grp(1-p, e);
            wc = gwp(p, e) - grp(p, e-2);
            xd = i_oe[p] ? int'(outr[p]) : 0;
            chk(cur_req, p ? "b_dout" : "a_dout", p ? int'(b_dout) : int'(a_dout), xd);
            chk("R4", p ? "b_empty" : "a_empty", p ? int'(b_empty) : int'(a_empty), int'(rc == 0));
            chk("R4", p ? "b_full" : "a_full", p ? int'(b_full) : int'(a_full), int'(wc == DEPTH));
            chk("R7", p ? "b_aempty" : "a_aempty", p ? int'(b_aempty) : int'(a_aempty), int'(rc <= aeo[p]));
            chk("R7", p ? "b_afull" : "a_afull", p ? int'(b_afull) : int'(a_afull), int'(wc + afo[p] >= DEPTH));
            chk("R9", p ? "b_byp" : "a_byp", p ? int'(b_byp) : int'(a_byp),
                int'((goff(1-p, e-2) | goff(1-p, e-3)) != 0));
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #5;
        compare();
    endtask

    task automatic cmd(int p, bit rw, int addr, int din);
        i_cs[p] = 1'b1; i_en[p] = 1'b1; i_rw[p] = rw;
        i_addr[p] = 3'(addr); i_din[p] = W'(din);
    endtask

    task automatic idle(int p);
        i_cs[p] = 1'b0; i_en[p] = 1'b0; i_rw[p] = 1'b0; i_addr[p] = 3'd0;
    endtask

    task automatic idle_both(int n);
        idle(0); idle(1);
        for (int k = 0; k < n; k++) tick();
    endtask

    initial begin
        for (int p = 0; p < 2; p++) begin
            idle(p); i_oe[p] = 1'b1; i_din[p] = '0;
            inreg[p] = '0; outr[p] = '0; aeo[p] = 0; afo[p] = 0;
        end
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        // R1: state straight after reset
        cur_req = "R1";
        compare();

        // R6: program and read back offsets on both ports
        cur_req = "R6";
        cmd(0, 0, 2, 3); cmd(1, 0, 2, 1); tick();
        cmd(0, 0, 3, 2); cmd(1, 0, 3, 'h3F1); tick();
        cmd(0, 1, 2, 0); cmd(1, 1, 3, 0); tick();
        cmd(0, 1, 3, 0); cmd(1, 1, 2, 0); tick();

        // R2: traffic in both directions, then drain in order
        cur_req = "R2";
        for (int k = 0; k < 5; k++) begin
            cmd(0, 0, 0, 'h100 + k);
            if (k < 3) cmd(1, 0, 0, 'h200 + k); else idle(1);
            tick();
        end
        idle_both(3);
        for (int k = 0; k < 5; k++) begin
            cmd(1, 1, 0, 0);
            if (k < 3) cmd(0, 1, 0, 0); else idle(0);
            tick();
        end

        // R3: reads while empty hold; writes past full are dropped
        cur_req = "R3";
        cmd(0, 1, 0, 0); cmd(1, 1, 0, 0); tick(); tick();
        idle(1);
        for (int k = 0; k < DEPTH + 3; k++) begin
            cmd(0, 0, 0, 'h300 + k); tick();
        end
        idle_both(3);
        for (int k = 0; k < DEPTH + 2; k++) begin
            cmd(1, 1, 0, 0); tick();
        end

        // R5: commands without both chip select and enable are ignored
        cur_req = "R5";
        idle(1);
        cmd(0, 0, 0, 'h0AA); tick();
        cmd(0, 0, 0, 'h0BB); tick();
        idle_both(3);
        cmd(1, 1, 0, 0); i_en[1] = 1'b0; tick();
        cmd(1, 1, 0, 0); i_cs[1] = 1'b0; tick();
        cmd(0, 1, 3, 0); i_en[0] = 1'b0; cmd(1, 1, 0, 0); tick();
        tick();

        // R10: addresses 100..111 are no-operations
        cur_req = "R10";
        cmd(0, 0, 5, 'h3AB); cmd(1, 1, 4, 0); tick();
        cmd(0, 0, 7, 'h3AB); cmd(1, 1, 6, 0); tick();
        idle(0); cmd(1, 1, 7, 0); tick();
        idle_both(3);

        // R9: A offers bypass for three clocks, B reads the direct path throughout
        cur_req = "R9";
        cmd(0, 0, 0, 'h0C1); tick();
        cmd(0, 0, 0, 'h0C2); tick();
        idle_both(3);
        for (int k = 0; k < 9; k++) begin
            if (k < 3) cmd(0, 0, 1, 'h155); else idle(0);
            cmd(1, 1, 1, 0);
            tick();
        end

        // R8: B offers bypass, A reads the direct path; stores stay untouched
        cur_req = "R8";
        idle(1);
        for (int k = 0; k < 8; k++) begin
            if (k < 4) cmd(1, 0, 1, 'h2AA); else idle(1);
            if (k >= 3 && k < 6) cmd(0, 1, 1, 0); else idle(0);
            tick();
        end
        idle_both(3);

        // R11: output enable low blanks the data output only
        cur_req = "R11";
        i_oe[0] = 1'b0; cmd(0, 1, 2, 0); tick();
        idle(0); tick();
        i_oe[0] = 1'b1; tick();
        idle_both(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule